// File: doc/BRIEF.md
# Explicit-Forwarding Result Routing Network

This block carries results between the functional units of a processor whose instructions name the destination of their result instead of a register. Each producing unit presents a result word with a 3-bit queue code. The network writes the word into the addressed operand queue. Each consuming unit takes values from the head of its own queue. Every queue is a small FIFO, so two values sent by one producer to one queue arrive in the order they were sent. Each value is consumed exactly once.

When several producers aim at the same queue in the same cycle, a per-queue round-robin arbiter accepts one of them. The others wait with their outputs held steady. A full queue holds its producers back through the ready signal. A consumer that finds its queue empty simply waits.

Comparison results travel on a separate one-bit path. That path has its own arbiters and queues, and it reaches only the two condition queues: the move unit's and the branch unit's. A synchronous flush empties every queue at once, for recovery after a deadlock timeout.

Top module: `res_route_net`

## Requirements
- R1: Queue codes are 0 = ALU operand A, 1 = ALU operand B, 2 = register write data, 3 = memory address, 4 = memory store data, 5 = move operand A, 6 = move operand B, 7 = branch target. A word is accepted at a rising edge where `src_valid` and `src_ready` are both high. A word accepted with code k becomes visible only on queue k, from the cycle after acceptance.
- R2: Words sent by one producer to one queue are delivered in the order they were accepted.
- R3: `q_valid[k]` is high exactly when queue k holds an entry. A rising edge with `q_valid[k]` and `q_ready[k]` both high removes the head entry, so each entry is delivered once.
- R4: Raising `q_ready` on an empty queue has no effect. The queue stays empty with count 0, and a word that arrives later is delivered normally.
- R5: Per queue, at most one producer is granted per cycle. The search for a grant starts at the producer index after the last one granted for that queue and wraps around; it starts at 0 after reset or flush. A waiting producer keeps `src_valid`, `src_dest` and `src_data` steady until it is granted.
- R6: No producer aiming at a full queue sees `src_ready` high, and the queue contents stay unchanged. A pop frees space that can be written in the cycle after the pop, not in the pop cycle itself.
- R7: Producers that target different queues in the same cycle are all accepted in that cycle.
- R8: A cycle with `flush` high grants no producer on either path. After that edge every data queue and condition queue is empty with count 0, and all arbiters restart their search at index 0.
- R9: On the boolean path, `bsrc_sel` = 0 targets the move-unit condition queue (`cq_*` bit 0) and 1 targets the branch-unit condition queue (`cq_*` bit 1). Boolean values never appear on the data queues. This path arbitrates and applies backpressure in the same way as the data queues.
- R10: `q_count[k]` gives the number of entries in queue k. `q_empty[k]` is high when the count is 0, and `q_full[k]` is high when the count equals the depth (default 4).
- R11: After reset, all queues are empty with count 0, `q_valid` and `cq_valid` are low, and no `src_ready` is raised while no producer is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all queues and arbiters |
| src_valid | input | NUM_SRC | Data producer offers a word |
| src_dest | input | NUM_SRC*3 | Queue code per producer |
| src_data | input | NUM_SRC*DATA_W | Result word per producer |
| src_ready | output | NUM_SRC | Producer's word is taken at this edge |
| bsrc_valid | input | NUM_BSRC | Boolean producer offers a value |
| bsrc_sel | input | NUM_BSRC | 0 move condition queue, 1 branch condition queue |
| bsrc_bit | input | NUM_BSRC | Boolean value |
| bsrc_ready | output | NUM_BSRC | Boolean value is taken at this edge |
| q_valid | output | 8 | Data queue holds an entry |
| q_ready | input | 8 | Consumer pops the head entry |
| q_data | output | 8*DATA_W | Head entry of each data queue |
| q_empty | output | 8 | Data queue empty |
| q_full | output | 8 | Data queue full |
| q_count | output | 8*CNT_W | Occupancy of each data queue |
| cq_valid | output | 2 | Condition queue holds an entry |
| cq_ready | input | 2 | Condition consumer pops |
| cq_bit | output | 2 | Head value of each condition queue |

## Verification
The hardest case to reach is the round-robin rotation on a single queue. Under contention it must give a different order from fixed priority. That only shows when a producer that has just won asks again while another producer is still waiting. The bench has two producers each send two words back to back into one queue, right after a flush has cleared all pointers. It then checks that the queue holds their words interleaved. A second hard case is a producer stalled on a full queue while the consumer pops. The bench holds the producer at the full queue and checks that its ready stays low through the pop cycle and rises one cycle later.

// File: rtl/rrn_pkg.sv
package rrn_pkg;

   localparam int QSEL_W = 3;
   localparam int NUM_DQ = 8;
   localparam int NUM_CQ = 2;
   localparam int CSEL_W = 1;

   typedef enum logic [QSEL_W-1:0] {
      Q_ALU_A    = 3'd0,
      Q_ALU_B    = 3'd1,
      Q_REG_WD   = 3'd2,
      Q_MEM_ADDR = 3'd3,
      Q_MEM_WD   = 3'd4,
      Q_MOV_A    = 3'd5,
      Q_MOV_B    = 3'd6,
      Q_BR_TGT   = 3'd7
   } dq_code_e;

   typedef enum logic [CSEL_W-1:0] {
      C_MOV_COND = 1'b0,
      C_BR_COND  = 1'b1
   } cq_code_e;

endpackage

// File: rtl/rrn_rr_arb.sv
module rrn_rr_arb #(
   parameter int N = 4,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic [N-1:0] req,
   input  logic         en,
   output logic [N-1:0] gnt
);

   initial begin : elab_chk
      assert (N >= 1) else $error("rrn_rr_arb: N must be at least 1");
   end

   generate
      if (N == 1) begin : g_single
         logic unused_ctl;
         assign unused_ctl = ^{clk, rst_n, flush};
         assign gnt = req & {N{en}};
      end else begin : g_rr
         localparam logic [IDX_W:0]   N_E  = (IDX_W+1)'(N);
         localparam logic [IDX_W-1:0] LAST = IDX_W'(N-1);

         logic [IDX_W-1:0] ptr_q;
         logic [IDX_W-1:0] gidx;
         logic [IDX_W:0]   cand;
         logic             found;

         always_comb begin
            gnt   = '0;
            gidx  = '0;
            cand  = '0;
            found = 1'b0;
            for (int k = 0; k < N; k++) begin
               cand = {1'b0, ptr_q} + (IDX_W+1)'(k);
               if (cand >= N_E) cand = cand - N_E;
               if (!found && en && req[cand[IDX_W-1:0]]) begin
                  gnt[cand[IDX_W-1:0]] = 1'b1;
                  gidx  = cand[IDX_W-1:0];
                  found = 1'b1;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ptr_q <= '0;
            else if (flush)   ptr_q <= '0;
            else if (found)   ptr_q <= (gidx == LAST) ? '0 : gidx + IDX_W'(1);
         end

         AST_RR_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
            (|gnt && |(req & ~gnt) && !flush) |=> (gnt != $past(gnt))) else $error("winner granted twice while others wait"); // R5
      end
   endgenerate

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)) else $error("more than one grant"); // R5
   AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0) else $error("grant without request"); // R5
   AST_GNT_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (gnt == '0)) else $error("grant while blocked"); // R6

endmodule

// File: rtl/rrn_fifo.sv
module rrn_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             rd_en,
   output logic [W-1:0]     rd_data,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] count
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   initial begin : elab_chk
      assert (DEPTH >= 2) else $error("rrn_fifo: DEPTH must be at least 2");
      assert (W >= 1)     else $error("rrn_fifo: W must be at least 1");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (POW2) begin : g_pow2
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_nxt;
         if (rd_en) rd_ptr <= rd_nxt;
         cnt_q <= cnt_q + CNT_W'(wr_en) - CNT_W'(rd_en);
      end
   end

   assign rd_data = mem[rd_ptr];
   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign count   = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full) else $error("write into full queue"); // R6
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty) else $error("pop from empty queue"); // R4
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0)) else $error("queue not empty after flush"); // R8
   AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && wr_en && !rd_en) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("count missed a write"); // R10
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && (wr_en == rd_en)) |=> $stable(cnt_q)) else $error("count moved without net change"); // R3

endmodule

// File: rtl/rrn_port_group.sv
module rrn_port_group #(
   parameter int NSRC  = 4,
   parameter int NDST  = 8,
   parameter int SEL_W = 3,
   parameter int W     = 32,
   parameter int DEPTH = 4,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic [NSRC-1:0]       in_valid,
   input  logic [NSRC*SEL_W-1:0] in_sel,
   input  logic [NSRC*W-1:0]     in_data,
   output logic [NSRC-1:0]       in_ready,
   output logic [NDST-1:0]       out_valid,
   input  logic [NDST-1:0]       out_ready,
   output logic [NDST*W-1:0]     out_data,
   output logic [NDST-1:0]       out_empty,
   output logic [NDST-1:0]       out_full,
   output logic [NDST*CNT_W-1:0] out_count
);

   initial begin : elab_chk
      assert (NDST <= (1 << SEL_W)) else $error("rrn_port_group: SEL_W too narrow for NDST");
      assert (NSRC >= 1)            else $error("rrn_port_group: NSRC must be at least 1");
   end

   logic [NDST*NSRC-1:0] gnt_all;

   for (genvar d = 0; d < NDST; d++) begin : g_dst
      logic [NSRC-1:0] req, gnt;
      logic [W-1:0]    wdata;
      logic            empty, full;

      always_comb begin
         for (int s = 0; s < NSRC; s++)
            req[s] = in_valid[s] && (in_sel[s*SEL_W +: SEL_W] == SEL_W'(d));
      end

      rrn_rr_arb #(.N(NSRC)) u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .flush (flush),
         .req   (req),
         .en    (!full && !flush),
         .gnt   (gnt)
      );

      always_comb begin
         wdata = '0;
         for (int s = 0; s < NSRC; s++)
            if (gnt[s]) wdata = wdata | in_data[s*W +: W];
      end

      rrn_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (flush),
         .wr_en   (|gnt),
         .wr_data (wdata),
         .rd_en   (out_ready[d] && !empty),
         .rd_data (out_data[d*W +: W]),
         .empty   (empty),
         .full    (full),
         .count   (out_count[d*CNT_W +: CNT_W])
      );

      assign out_valid[d] = !empty;
      assign out_empty[d] = empty;
      assign out_full[d]  = full;
      assign gnt_all[d*NSRC +: NSRC] = gnt;
   end

   always_comb begin
      for (int s = 0; s < NSRC; s++) begin
         in_ready[s] = 1'b0;
         for (int d = 0; d < NDST; d++)
            in_ready[s] = in_ready[s] | gnt_all[d*NSRC + s];
      end
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src_chk
      AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid[s] && !in_ready[s] && !flush) |=>
            (in_valid[s] && $stable(in_sel[s*SEL_W +: SEL_W]) && $stable(in_data[s*W +: W])))
         else $error("waiting producer changed its offer"); // R5
      AST_FLUSH_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
         flush |-> !in_ready[s]) else $error("grant during flush"); // R8
   end

endmodule

// File: rtl/res_route_net.sv
module res_route_net
   import rrn_pkg::*;
#(
   parameter int NUM_SRC  = 4,
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 4,
   parameter int NUM_BSRC = 2,
   parameter int CDEPTH   = 4,
   localparam int CNT_W   = $clog2(DEPTH + 1),
   localparam int CCNT_W  = $clog2(CDEPTH + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic [NUM_SRC-1:0]         src_valid,
   input  logic [NUM_SRC*QSEL_W-1:0]  src_dest,
   input  logic [NUM_SRC*DATA_W-1:0]  src_data,
   output logic [NUM_SRC-1:0]         src_ready,
   input  logic [NUM_BSRC-1:0]        bsrc_valid,
   input  logic [NUM_BSRC-1:0]        bsrc_sel,
   input  logic [NUM_BSRC-1:0]        bsrc_bit,
   output logic [NUM_BSRC-1:0]        bsrc_ready,
   output logic [NUM_DQ-1:0]          q_valid,
   input  logic [NUM_DQ-1:0]          q_ready,
   output logic [NUM_DQ*DATA_W-1:0]   q_data,
   output logic [NUM_DQ-1:0]          q_empty,
   output logic [NUM_DQ-1:0]          q_full,
   output logic [NUM_DQ*CNT_W-1:0]    q_count,
   output logic [NUM_CQ-1:0]          cq_valid,
   input  logic [NUM_CQ-1:0]          cq_ready,
   output logic [NUM_CQ-1:0]          cq_bit
);

   initial begin : elab_chk
      assert (NUM_SRC >= 1)  else $error("res_route_net: NUM_SRC must be at least 1");
      assert (NUM_BSRC >= 1) else $error("res_route_net: NUM_BSRC must be at least 1");
      assert (DATA_W >= 1)   else $error("res_route_net: DATA_W must be at least 1");
      assert (DEPTH >= 2)    else $error("res_route_net: DEPTH must be at least 2");
      assert (CDEPTH >= 2)   else $error("res_route_net: CDEPTH must be at least 2");
   end

   rrn_port_group #(
      .NSRC  (NUM_SRC),
      .NDST  (NUM_DQ),
      .SEL_W (QSEL_W),
      .W     (DATA_W),
      .DEPTH (DEPTH)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .in_valid  (src_valid),
      .in_sel    (src_dest),
      .in_data   (src_data),
      .in_ready  (src_ready),
      .out_valid (q_valid),
      .out_ready (q_ready),
      .out_data  (q_data),
      .out_empty (q_empty),
      .out_full  (q_full),
      .out_count (q_count)
   );

   logic [NUM_CQ-1:0]        cq_unused_empty;
   logic [NUM_CQ-1:0]        cq_unused_full;
   logic [NUM_CQ*CCNT_W-1:0] cq_unused_count;

   rrn_port_group #(
      .NSRC  (NUM_BSRC),
      .NDST  (NUM_CQ),
      .SEL_W (CSEL_W),
      .W     (1),
      .DEPTH (CDEPTH)
   ) u_bool (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .in_valid  (bsrc_valid),
      .in_sel    (bsrc_sel),
      .in_data   (bsrc_bit),
      .in_ready  (bsrc_ready),
      .out_valid (cq_valid),
      .out_ready (cq_ready),
      .out_data  (cq_bit),
      .out_empty (cq_unused_empty),
      .out_full  (cq_unused_full),
      .out_count (cq_unused_count)
   );

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid == '0) |-> (src_ready == '0)) else $error("ready without producer"); // R11
   AST_BOOL_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid == '0 && !flush && q_ready == '0) |=> $stable(q_count)) else $error("data queue moved without data traffic"); // R9

endmodule

// File: tb/tb_res_route_net.sv
module tb_res_route_net;
   import rrn_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 20000;
   localparam int NV         = 8;

   localparam int            V_SRC [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
   localparam logic [2:0]    V_DST [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
   localparam logic [31:0]   V_DAT [NV] = '{32'hA1B2C3D4, 32'h0000FFFF, 32'hFFFF0000, 32'h12345678,
                                            32'hDEADBEEF, 32'h00000001, 32'h80000000, 32'h5A5AA5A5};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         flush = 1'b0;
   logic [3:0]   src_valid = '0;
   logic [11:0]  src_dest = '0;
   logic [127:0] src_data = '0;
   logic [3:0]   src_ready;
   logic [1:0]   bsrc_valid = '0;
   logic [1:0]   bsrc_sel = '0;
   logic [1:0]   bsrc_bit = '0;
   logic [1:0]   bsrc_ready;
   logic [7:0]   q_valid;
   logic [7:0]   q_ready = '0;
   logic [255:0] q_data;
   logic [7:0]   q_empty;
   logic [7:0]   q_full;
   logic [23:0]  q_count;
   logic [1:0]   cq_valid;
   logic [1:0]   cq_ready = '0;
   logic [1:0]   cq_bit;

   int n_chk = 0;
   int n_fail = 0;

   res_route_net dut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .src_valid(src_valid), .src_dest(src_dest), .src_data(src_data), .src_ready(src_ready),
      .bsrc_valid(bsrc_valid), .bsrc_sel(bsrc_sel), .bsrc_bit(bsrc_bit), .bsrc_ready(bsrc_ready),
      .q_valid(q_valid), .q_ready(q_ready), .q_data(q_data), .q_empty(q_empty),
      .q_full(q_full), .q_count(q_count),
      .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_bit(cq_bit)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // starts and ends just after a rising edge
   task automatic send(input int s, input logic [2:0] d, input logic [31:0] w);
      src_valid[s] = 1'b1;
      src_dest[s*3 +: 3] = d;
      src_data[s*32 +: 32] = w;
      @(negedge clk);
      while (!src_ready[s]) @(negedge clk);
      step();
      src_valid[s] = 1'b0;
   endtask

   task automatic pop_expect(input int q, input logic [31:0] w, input string tag);
      @(negedge clk);
      check(tag, q_valid[q], 1);
      check(tag, q_data[q*32 +: 32], w);
      q_ready[q] = 1'b1;
      step();
      q_ready[q] = 1'b0;
   endtask

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      @(negedge clk);
      check("R11 q_valid", q_valid, 0);
      check("R11 q_empty", q_empty, 8'hFF);
      check("R11 q_count", q_count, 0);
      check("R11 cq_valid", cq_valid, 0);
      check("R11 src_ready", src_ready, 0);
      step();

      // R1 R3 R10: vector table walk
      for (int v = 0; v < NV; v++) begin
         int d;
         d = int'(V_DST[v]);
         send(V_SRC[v], V_DST[v], V_DAT[v]);
         @(negedge clk);
         check("R1 only addressed queue valid", q_valid, 64'(8'(1) << d));
         check("R1 data", q_data[d*32 +: 32], V_DAT[v]);
         check("R10 count one", q_count[d*3 +: 3], 1);
         q_ready[d] = 1'b1;
         step();
         q_ready[d] = 1'b0;
         @(negedge clk);
         check("R3 popped once", q_valid, 0);
         check("R10 empty flag", q_empty[d], 1);
         step();
      end

      // R2 order from one producer
      send(1, Q_REG_WD, 32'h11);
      send(1, Q_REG_WD, 32'h22);
      send(1, Q_REG_WD, 32'h33);
      @(negedge clk);
      check("R10 count three", q_count[2*3 +: 3], 3);
      step();
      pop_expect(2, 32'h11, "R2 order");
      pop_expect(2, 32'h22, "R2 order");
      pop_expect(2, 32'h33, "R2 order");

      // R7 distinct queues same cycle
      for (int s = 0; s < 4; s++) begin
         src_valid[s] = 1'b1;
         src_dest[s*3 +: 3] = 3'(s + 3);
         src_data[s*32 +: 32] = 32'(100 + s);
      end
      @(negedge clk);
      check("R7 all ready", src_ready, 4'hF);
      step();
      src_valid = '0;
      @(negedge clk);
      check("R7 all written", q_valid, 8'b0111_1000);
      step();
      for (int s = 0; s < 4; s++) pop_expect(s + 3, 32'(100 + s), "R7 data");

      // R8 flush
      send(0, Q_MEM_WD, 32'hF0);
      send(1, Q_MOV_B, 32'hF1);
      bsrc_valid = 2'b01; bsrc_sel = 2'b01; bsrc_bit = 2'b01;
      step();
      bsrc_valid = '0;
      flush = 1'b1;
      src_valid[0] = 1'b1; src_dest[2:0] = Q_BR_TGT; src_data[31:0] = 32'hBAD;
      @(negedge clk);
      check("R8 no grant in flush", src_ready, 0);
      step();
      flush = 1'b0;
      src_valid = '0;
      @(negedge clk);
      check("R8 queues empty", q_empty, 8'hFF);
      check("R8 counts zero", q_count, 0);
      check("R8 cond empty", cq_valid, 0);
      step();

      // R5 contention, pointers at 0 after flush
      fork
         send(0, Q_ALU_A, 32'hC0DE0000);
         send(1, Q_ALU_A, 32'hC0DE0001);
         send(2, Q_ALU_A, 32'hC0DE0002);
         send(3, Q_ALU_A, 32'hC0DE0003);
      join
      @(negedge clk);
      check("R10 count full", q_count[2:0], 4);
      check("R10 full flag", q_full[0], 1);
      step();

      // R6 backpressure on full queue
      src_valid[2] = 1'b1; src_dest[8:6] = Q_ALU_A; src_data[95:64] = 32'hE0E0E0E0;
      @(negedge clk);
      check("R6 blocked", src_ready[2], 0);
      step();
      @(negedge clk);
      check("R6 still blocked", src_ready[2], 0);
      check("R6 count unchanged", q_count[2:0], 4);
      check("R5 head first winner", q_data[31:0], 32'hC0DE0000);
      q_ready[0] = 1'b1;
      step();
      q_ready[0] = 1'b0;
      @(negedge clk);
      check("R6 ready after pop", src_ready[2], 1);
      check("R6 count after pop", q_count[2:0], 3);
      step();
      src_valid[2] = 1'b0;
      pop_expect(0, 32'hC0DE0001, "R5 rr order");
      pop_expect(0, 32'hC0DE0002, "R5 rr order");
      pop_expect(0, 32'hC0DE0003, "R5 rr order");
      pop_expect(0, 32'hE0E0E0E0, "R6 late word");

      // R5 rotation differs from fixed priority
      fork
         begin send(0, Q_ALU_B, 32'hA0); send(0, Q_ALU_B, 32'hA1); end
         begin send(1, Q_ALU_B, 32'hB0); send(1, Q_ALU_B, 32'hB1); end
      join
      pop_expect(1, 32'hA0, "R5 rotate");
      pop_expect(1, 32'hB0, "R5 rotate");
      pop_expect(1, 32'hA1, "R5 rotate");
      pop_expect(1, 32'hB1, "R5 rotate");

      // R4 pop of empty queue
      q_ready[3] = 1'b1;
      @(negedge clk);
      check("R4 empty stays", q_valid[3], 0);
      step();
      @(negedge clk);
      check("R4 count zero", q_count[9:11-2], 0);
      check("R4 empty flag", q_empty[3], 1);
      step();
      send(2, Q_MEM_ADDR, 32'h77);
      @(negedge clk);
      check("R4 later word valid", q_valid[3], 1);
      check("R4 later word data", q_data[3*32 +: 32], 32'h77);
      step();
      q_ready[3] = 1'b0;
      @(negedge clk);
      check("R3 consumed once", q_count[9 +: 3], 0);
      step();

      // R9 boolean path
      bsrc_valid = 2'b11; bsrc_sel = 2'b01; bsrc_bit = 2'b01;
      @(negedge clk);
      check("R9 both taken", bsrc_ready, 2'b11);
      step();
      bsrc_valid = '0;
      @(negedge clk);
      check("R9 cond valid", cq_valid, 2'b11);
      check("R9 cond bits", cq_bit, 2'b10);
      check("R9 data queues untouched", q_valid, 0);
      cq_ready = 2'b11;
      step();
      cq_ready = '0;
      @(negedge clk);
      check("R9 cond popped", cq_valid, 0);
      step();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule